// File: doc/BRIEF.md
# LED Transmit FIFO and Request Logic

This block holds the pixel words waiting to be shifted out to a chain of addressable LEDs. Software or a DMA engine pushes 32-bit words into a 32-entry queue. The LED bit serializer pops them from the other end. Each word is visible at the read side before it is popped.

The fill level is compared against a programmable trigger. When DMA is enabled, a DMA request is raised while the free space is at least the trigger value. When DMA is disabled, a refill status flag is latched instead, so the processor can top the queue up. A second status flag records the serializer's end-of-transfer pulse. Both flags are cleared by writing ones. They are combined into one interrupt line through per-source enables and a global enable.

Starting a new transfer empties the queue. The bus decoder, the serializer and the DMA engine sit outside this block and connect through plain strobes.

Top module: `led_txfifo_ctl`

## Requirements
- R1: Each cycle with `data_we` high and the queue not full stores `data_wdata`. The level rises by one on the next edge. `ser_data` always shows the oldest stored word, and `ser_pop` removes it, so words come out in write order.
- R2: A write while the level equals the depth (32) is dropped. The level stays 32, and the 32 stored words come out unchanged and in order.
- R3: A pop while the queue is empty is ignored. The level stays 0, and the next word written is the next word read.
- R4: A `xfer_start` pulse empties the queue at the next edge. A write or pop in the same cycle is ignored.
- R5: `status_word` has these fields:
  - the level in bits 15:10;
  - the refill flag in bit 1;
  - the finish flag in bit 0;
  - zero in bits 9:2.
- R6: The DMA setting written through `dma_cfg_wdata` holds the enable in bit 5 and the trigger in bits 4:0. `dma_req` is high exactly when the enable is set and (32 minus level) is at least the trigger.
- R7: With the DMA enable clear, the refill flag is set at every edge where (32 minus level) is at least the trigger. With the enable set, the level never sets it.
- R8: A `xfer_done` pulse sets the finish flag at the next edge.
- R9: Writing `sts_clr_wdata` with `sts_clr_we` clears each flag whose bit is 1 (bit 1 refill, bit 0 finish). It leaves flags whose bit is 0 unchanged. A set event in the same cycle wins over the clear.
- R10: The interrupt setting holds the global enable in bit 5, the refill enable in bit 1 and the finish enable in bit 0. `irq` is the global enable AND (finish flag AND its enable, OR refill flag AND its enable).
- R11: During reset the following all hold:
  - the queue is empty (`ser_empty` high);
  - both settings are zero;
  - `status_word` is zero;
  - `dma_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_we | input | 1 | Push strobe for the data word |
| data_wdata | input | 32 | Word to push |
| dma_cfg_we | input | 1 | Load strobe for the DMA setting |
| dma_cfg_wdata | input | 6 | DMA enable (bit 5) and trigger (bits 4:0) |
| irq_cfg_we | input | 1 | Load strobe for the interrupt setting |
| irq_cfg_wdata | input | 6 | Global enable (bit 5), refill enable (bit 1), finish enable (bit 0) |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the status flags |
| sts_clr_wdata | input | 2 | Clear mask: bit 1 refill, bit 0 finish |
| xfer_start | input | 1 | New transfer begins; empties the queue |
| xfer_done | input | 1 | End-of-transfer pulse from the serializer |
| ser_pop | input | 1 | Serializer takes the oldest word |
| ser_data | output | 32 | Oldest stored word |
| ser_empty | output | 1 | Queue holds no word |
| status_word | output | 16 | Level and flags, see R5 |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set event and a clear in the same cycle. The refill flag's set condition is a level comparison, so the stimulus first fills the queue past the trigger. It then clears the flag while the condition is false, and pops until free space meets the trigger exactly. The clear is then issued while the condition holds, and the flag must survive. The overflow case is reached by filling all 32 entries and pushing once more. Every word is then drained, and each one is compared with what was written.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

  // Free entries left in a queue of the given depth.
  function automatic int unsigned free_words(input int unsigned depth, input int unsigned level);
    return (level <= depth) ? (depth - level) : 0;
  endfunction

  // True when the free space reaches the programmed trigger.
  function automatic logic meets_trigger(input int unsigned depth, input int unsigned level,
                                         input int unsigned trig);
    return free_words(depth, level) >= trig;
  endfunction

endpackage

// File: rtl/ltx_fifo_store.sv
module ltx_fifo_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [LW-1:0]    level,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2: the level never passes the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2: a write into a full queue leaves it full and the write pointer still
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (level == LW'(DEPTH)) && $stable(wr_ptr));

  // R3: a pop on an empty queue leaves it empty
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (level == '0) && $stable(rd_ptr));

  // R4: a new transfer starts from an empty queue
  p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

endmodule

// File: rtl/ltx_req_gen.sv
module ltx_req_gen #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic [LW-1:0] level,
  input  logic          dma_en,
  input  logic [AW-1:0] trig,
  output logic          dma_req,
  output logic          refill_set
);

  logic room_ok;

  assign room_ok    = ltx_pkg::meets_trigger(DEPTH, 32'(level), 32'(trig));
  assign dma_req    = dma_en && room_ok;
  assign refill_set = !dma_en && room_ok;

endmodule

// File: rtl/ltx_irq_stat.sv
module ltx_irq_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  input  logic       clr_we,
  input  logic [1:0] clr_mask,
  input  logic       done_set,
  input  logic       refill_set,
  output logic [1:0] sts,
  output logic       irq
);

  logic       gie_q;
  logic [1:0] src_en_q;
  logic [1:0] set_vec, clr_vec, armed;

  assign set_vec = {refill_set, done_set};
  assign clr_vec = clr_we ? clr_mask : 2'b00;
  assign armed   = sts & src_en_q;
  assign irq     = gie_q && (armed != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      src_en_q <= 2'b00;
      sts      <= 2'b00;
    end else begin
      if (cfg_we) begin
        gie_q    <= cfg_wdata[5];
        src_en_q <= cfg_wdata[1:0];
      end
      sts <= set_vec | (sts & ~clr_vec);
    end
  end

  // R8: the end-of-transfer pulse is latched
  p_done_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> sts[0]);

  // R9: a clear without a competing set takes effect
  p_w1c_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[0] && !done_set) |=> !sts[0]);

  // R9: a zero mask bit leaves the refill flag alone
  p_w1c_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !(clr_we && clr_mask[1])) |=> sts[1]);

  // R10: an interrupt always has a pending source behind it
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != 2'b00));

endmodule

// File: rtl/led_txfifo_ctl.sv
module led_txfifo_ctl #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       data_we,
  input  logic [WIDTH-1:0]           data_wdata,
  input  logic                       dma_cfg_we,
  input  logic [$clog2(DEPTH):0]     dma_cfg_wdata,
  input  logic                       irq_cfg_we,
  input  logic [5:0]                 irq_cfg_wdata,
  input  logic                       sts_clr_we,
  input  logic [1:0]                 sts_clr_wdata,
  input  logic                       xfer_start,
  input  logic                       xfer_done,
  input  logic                       ser_pop,
  output logic [WIDTH-1:0]           ser_data,
  output logic                       ser_empty,
  output logic [10+$clog2(DEPTH):0]  status_word,
  output logic                       dma_req,
  output logic                       irq
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [AW:0]   dma_cfg_q;
  logic          dma_en;
  logic [AW-1:0] trig;
  logic [LW-1:0] level;
  logic          full;
  logic          refill_set;
  logic [1:0]    sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dma_cfg_q <= '0;
    else if (dma_cfg_we) dma_cfg_q <= dma_cfg_wdata;
  end

  assign dma_en = dma_cfg_q[AW];
  assign trig   = dma_cfg_q[AW-1:0];

  ltx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(xfer_start),
    .push(data_we), .push_data(data_wdata),
    .pop(ser_pop), .pop_data(ser_data),
    .level(level), .empty(ser_empty), .full(full)
  );

  ltx_req_gen #(.DEPTH(DEPTH)) u_req (
    .level(level), .dma_en(dma_en), .trig(trig),
    .dma_req(dma_req), .refill_set(refill_set)
  );

  ltx_irq_stat u_irq (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(irq_cfg_we), .cfg_wdata(irq_cfg_wdata),
    .clr_we(sts_clr_we), .clr_mask(sts_clr_wdata),
    .done_set(xfer_done), .refill_set(refill_set),
    .sts(sts), .irq(irq)
  );

  assign status_word = {level, 8'b0, sts};

  // R6: a DMA request never appears with DMA disabled or with a full queue and nonzero trigger
  p_dma_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en && !(full && trig != '0)));

  // R7: with DMA enabled the refill flag cannot rise
  p_refill_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !sts[1]) |=> !sts[1]);

endmodule

// File: tb/led_txfifo_ctl_bench.sv
module led_txfifo_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_we = 1'b0;
  logic [31:0] data_wdata = '0;
  logic        dma_cfg_we = 1'b0;
  logic [5:0]  dma_cfg_wdata = '0;
  logic        irq_cfg_we = 1'b0;
  logic [5:0]  irq_cfg_wdata = '0;
  logic        sts_clr_we = 1'b0;
  logic [1:0]  sts_clr_wdata = '0;
  logic        xfer_start = 1'b0;
  logic        xfer_done = 1'b0;
  logic        ser_pop = 1'b0;
  logic [31:0] ser_data;
  logic        ser_empty;
  logic [15:0] status_word;
  logic        dma_req;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  led_txfifo_ctl u_led_txfifo_ctl (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
    .dma_cfg_we(dma_cfg_we), .dma_cfg_wdata(dma_cfg_wdata),
    .irq_cfg_we(irq_cfg_we), .irq_cfg_wdata(irq_cfg_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_wdata(sts_clr_wdata),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .ser_pop(ser_pop),
    .ser_data(ser_data), .ser_empty(ser_empty), .status_word(status_word),
    .dma_req(dma_req), .irq(irq)
  );

  typedef struct packed {
    logic [5:0] npush;
    logic [5:0] npop;
    logic       en;
    logic [4:0] trig;
    logic [5:0] lvl;
    logic       dma;
  } vec_t;

  // level = pushes - pops; dma = en && (32 - level >= trig)
  localparam vec_t VECS [9] = '{
    '{6'd0,  6'd0,  1'b1, 5'd16, 6'd0,  1'b1},
    '{6'd16, 6'd0,  1'b1, 5'd16, 6'd16, 1'b1},
    '{6'd17, 6'd0,  1'b1, 5'd16, 6'd17, 1'b0},
    '{6'd32, 6'd0,  1'b1, 5'd1,  6'd32, 1'b0},
    '{6'd31, 6'd0,  1'b1, 5'd1,  6'd31, 1'b1},
    '{6'd20, 6'd5,  1'b1, 5'd17, 6'd15, 1'b1},
    '{6'd20, 6'd4,  1'b1, 5'd17, 6'd16, 1'b0},
    '{6'd10, 6'd0,  1'b0, 5'd0,  6'd10, 1'b0},
    '{6'd32, 6'd32, 1'b1, 5'd31, 6'd0,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_push(input logic [31:0] d);
    data_we = 1'b1; data_wdata = d; tick(); data_we = 1'b0;
  endtask
  task automatic do_pop;
    ser_pop = 1'b1; tick(); ser_pop = 1'b0;
  endtask
  task automatic do_flush;
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
  endtask
  task automatic set_dma(input logic en, input logic [4:0] t);
    dma_cfg_we = 1'b1; dma_cfg_wdata = {en, t}; tick(); dma_cfg_we = 1'b0;
  endtask
  task automatic set_irq(input logic [5:0] v);
    irq_cfg_we = 1'b1; irq_cfg_wdata = v; tick(); irq_cfg_we = 1'b0;
  endtask
  task automatic clr_sts(input logic [1:0] m);
    sts_clr_we = 1'b1; sts_clr_wdata = m; tick(); sts_clr_we = 1'b0;
  endtask

  function automatic logic [31:0] lvl_of(input logic [15:0] s);
    return 32'(s[15:10]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R11: reset state
    chk("R11 status", 32'(status_word), 0);
    chk("R11 dma_req", 32'(dma_req), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 empty", 32'(ser_empty), 1);
    rst_n = 1'b1;
    tick();

    // R6 / R1: table walk
    foreach (VECS[i]) begin
      do_flush();
      set_dma(VECS[i].en, VECS[i].trig);
      for (int k = 0; k < int'(VECS[i].npush); k++) do_push(32'(k));
      for (int k = 0; k < int'(VECS[i].npop); k++) do_pop();
      chk($sformatf("R1 level vec %0d", i), lvl_of(status_word), 32'(VECS[i].lvl));
      chk($sformatf("R6 dma_req vec %0d", i), 32'(dma_req), 32'(VECS[i].dma));
    end

    // R1: write order
    set_dma(1'b1, 5'd0);
    do_flush();
    do_push(32'hA1); do_push(32'hB2); do_push(32'hC3);
    chk("R1 level 3", lvl_of(status_word), 3);
    chk("R1 first", ser_data, 32'hA1); do_pop();
    chk("R1 second", ser_data, 32'hB2); do_pop();
    chk("R1 third", ser_data, 32'hC3); do_pop();
    chk("R1 drained", 32'(ser_empty), 1);

    // R2: overflow dropped
    do_flush();
    for (int k = 0; k < 32; k++) do_push(32'h100 + 32'(k));
    do_push(32'hDEAD);
    chk("R2 level full", lvl_of(status_word), 32);
    for (int k = 0; k < 32; k++) begin
      chk($sformatf("R2 word %0d", k), ser_data, 32'h100 + 32'(k));
      do_pop();
    end
    chk("R2 empty after drain", 32'(ser_empty), 1);

    // R3: pop on empty ignored
    do_pop();
    chk("R3 level stays 0", lvl_of(status_word), 0);
    do_push(32'h77);
    chk("R3 next word", ser_data, 32'h77);
    chk("R3 level 1", lvl_of(status_word), 1);

    // R4: flush wins over a same-cycle push
    do_push(32'h78);
    xfer_start = 1'b1; data_we = 1'b1; data_wdata = 32'h99; tick();
    xfer_start = 1'b0; data_we = 1'b0;
    chk("R4 level 0", lvl_of(status_word), 0);
    chk("R4 empty", 32'(ser_empty), 1);

    // R7 / R9: refill flag with DMA off, trigger 16
    set_dma(1'b0, 5'd16);
    for (int k = 0; k < 20; k++) do_push(32'(k));
    clr_sts(2'b10);
    chk("R7 refill clear while free 12", 32'(status_word[1]), 0);
    chk("R5 reserved bits", 32'(status_word[9:2]), 0);
    for (int k = 0; k < 4; k++) do_pop();
    tick();
    chk("R7 refill set at free 16", 32'(status_word[1]), 1);
    clr_sts(2'b10);
    chk("R9 set wins over clear", 32'(status_word[1]), 1);
    set_dma(1'b1, 5'd16);
    clr_sts(2'b10);
    chk("R7 refill quiet with DMA on", 32'(status_word[1]), 0);
    chk("R6 dma_req at free 16", 32'(dma_req), 1);

    // R8 / R9: finish flag
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    chk("R8 finish latched", 32'(status_word[0]), 1);
    clr_sts(2'b10);
    chk("R9 zero mask keeps finish", 32'(status_word[0]), 1);

    // R10: interrupt gating
    set_irq(6'b000001);
    chk("R10 no global", 32'(irq), 0);
    set_irq(6'b100001);
    chk("R10 finish source", 32'(irq), 1);
    set_irq(6'b100010);
    chk("R10 refill disabled source", 32'(irq), 0);

    clr_sts(2'b01);
    chk("R9 finish cleared", 32'(status_word[0]), 0);
    xfer_done = 1'b1; sts_clr_we = 1'b1; sts_clr_wdata = 2'b01; tick();
    xfer_done = 1'b0; sts_clr_we = 1'b0;
    chk("R9 done wins over clear", 32'(status_word[0]), 1);

    set_dma(1'b0, 5'd0);
    tick();
    chk("R10 refill source", 32'(irq), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule